// File: doc/BRIEF.md
# Hardware-Updated Status Field

This block holds one status value, eight bits wide by default, that hardware logic keeps up to date while software reads it and may overwrite it through a small word-wide access port. Hardware changes the value in three ways. A load captures a new value from an input bus when the load control is at its active level, and that level is chosen by a parameter. A clear forces bits to zero. A set forces bits to one.

Every hardware change passes through a per-bit filter. A software-written filter vector either enables bits (a 1 lets the bit change) or protects them (a 1 freezes the bit), and a parameter picks which of the two meanings applies. Besides the dedicated pins, software can trigger a load, clear or set through a self-clearing command register. The block also drives the AND, OR and XOR reductions of the stored value at all times.

Each cycle the update selector picks exactly one update kind, in this priority order. `UPD_SWWR` is a software write to the field. `UPD_HSET` is a hardware set. `UPD_HCLR` is a hardware clear. `UPD_HLOAD` is a hardware load. `UPD_HOLD` means nothing is asserted. The selection is made afresh every cycle. Whatever the previous kind was, the next one follows from the highest-priority request present, and the selector returns to `UPD_HOLD` whenever no request is present.

Top module: `hwst_field`

## Requirements
- R1: During and after synchronous reset, the field equals RESET_VAL, the filter vector equals FILT_RESET, and address 2 reads as zero.
- R2: With FILTER_IS_MASK=0, a hardware load, clear or set changes only the bits whose filter bit is 1. With filter 0xF0 and field 0x11: a load of 0xAB gives 0xA1, a clear then gives 0x01, and a set then gives 0xF1.
- R3: With FILTER_IS_MASK=1, bits whose filter bit is 1 are protected and the other bits may change. With filter 0xF0 and field 0x22: a load of 0xAB gives 0x2B, a clear then gives 0x20, and a set then gives 0x2F.
- R4: With LOAD_ACTIVE_LOW=0 a load happens when hw_load is 1. With LOAD_ACTIVE_LOW=1 a load happens when hw_load is 0. At the inactive level, hw_value has no effect.
- R5: When requests coincide, set wins over clear and clear wins over load.
- R6: A software write to address 0 replaces the whole field without filtering, and it wins over any hardware request in the same cycle. The new value is visible one cycle after the write.
- R7: red_and is 1 only for an all-ones field, red_or is 1 for any nonzero field, and red_xor is the odd parity of the field. Examples: 0x00 gives 0,0,0; 0x03 gives 0,1,0; 0xFE gives 0,1,1; 0xFF gives 1,1,0.
- R8: A write to address 2 issues command pulses: bit 0 is load (captures hw_value), bit 1 is clear and bit 2 is set. The pulses take effect at the clock edge after the write and are filtered like the pins. Address 2 always reads as zero.
- R9: Address 0 reads the field and address 1 reads and writes the filter vector. Address 3 reads as zero, and a write to it changes neither the field nor the filter vector.
- R10: With no request present, the field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 2 | Access address: 0 = field, 1 = filter vector, 2 = command, 3 = unused |
| acc_wr | input | 1 | Write strobe for one cycle |
| acc_wdata | input | WIDTH | Write data |
| acc_rdata | output | WIDTH | Read data for acc_addr (combinational) |
| hw_value | input | WIDTH | Value captured by a hardware load |
| hw_load | input | 1 | Load request, polarity set by LOAD_ACTIVE_LOW |
| hw_clr | input | 1 | Clear request |
| hw_set | input | 1 | Set request |
| fld_value | output | WIDTH | Stored field value |
| red_and | output | 1 | AND reduction of the field |
| red_or | output | 1 | OR reduction of the field |
| red_xor | output | 1 | XOR reduction of the field |

## Verification
The assertions assume that inputs are stable and known at every sampled edge once reset is released. They also assume that the filter is applied to one whole-word software write at a time, and that WIDTH is at least 3 so that all command bits exist. The stimulus changes inputs only just after a rising edge and returns every request to its idle level, which for the active-low instance means hw_load high. Each software write lasts exactly one cycle. A second instance, with mask filtering and active-low load, covers the other parameter variants under the same rules.

// File: rtl/hwst_pkg.sv
package hwst_pkg;

    typedef enum logic [2:0] {
        UPD_HOLD  = 3'd0,
        UPD_SWWR  = 3'd1,
        UPD_HSET  = 3'd2,
        UPD_HCLR  = 3'd3,
        UPD_HLOAD = 3'd4
    } upd_kind_t;

    localparam logic [1:0] ADDR_FIELD = 2'd0;
    localparam logic [1:0] ADDR_FILT  = 2'd1;
    localparam logic [1:0] ADDR_CMD   = 2'd2;

    localparam int CMD_LOAD_BIT = 0;
    localparam int CMD_CLR_BIT  = 1;
    localparam int CMD_SET_BIT  = 2;

endpackage

// File: rtl/hwst_access.sv
module hwst_access
    import hwst_pkg::*;
#(
    parameter int          WIDTH      = 8,
    parameter logic [WIDTH-1:0] FILT_RESET = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       acc_addr,
    input  logic             acc_wr,
    input  logic [WIDTH-1:0] acc_wdata,
    input  logic [WIDTH-1:0] fld_q,
    output logic [WIDTH-1:0] acc_rdata,
    output logic [WIDTH-1:0] filt_vec,
    output logic             cmd_load,
    output logic             cmd_clr,
    output logic             cmd_set,
    output logic             sw_fld_wr
);

    logic wr_filt;
    logic wr_cmd;

    always_comb begin
        sw_fld_wr = acc_wr && (acc_addr == ADDR_FIELD);
        wr_filt   = acc_wr && (acc_addr == ADDR_FILT);
        wr_cmd    = acc_wr && (acc_addr == ADDR_CMD);
    end

    // Filter vector register
    always_ff @(posedge clk) begin
        if (rst) begin
            filt_vec <= FILT_RESET;
        end else if (wr_filt) begin
            filt_vec <= acc_wdata;
        end
    end

    // Self-clearing command pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_load <= 1'b0;
            cmd_clr  <= 1'b0;
            cmd_set  <= 1'b0;
        end else begin
            cmd_load <= wr_cmd && acc_wdata[CMD_LOAD_BIT];
            cmd_clr  <= wr_cmd && acc_wdata[CMD_CLR_BIT];
            cmd_set  <= wr_cmd && acc_wdata[CMD_SET_BIT];
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (acc_addr)
            ADDR_FIELD: acc_rdata = fld_q;
            ADDR_FILT:  acc_rdata = filt_vec;
            default:    acc_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hwst_update.sv
module hwst_update
    import hwst_pkg::*;
#(
    parameter int WIDTH           = 8,
    parameter bit FILTER_IS_MASK  = 1'b0,
    parameter bit LOAD_ACTIVE_LOW = 1'b0
) (
    input  logic             sw_fld_wr,
    input  logic [WIDTH-1:0] sw_wdata,
    input  logic [WIDTH-1:0] fld_q,
    input  logic [WIDTH-1:0] filt_vec,
    input  logic [WIDTH-1:0] hw_value,
    input  logic             hw_load,
    input  logic             hw_clr,
    input  logic             hw_set,
    input  logic             cmd_load,
    input  logic             cmd_clr,
    input  logic             cmd_set,
    output logic [WIDTH-1:0] allowed,
    output logic             eff_load,
    output logic             eff_clr,
    output logic             eff_set,
    output logic [WIDTH-1:0] fld_d
);

    logic      load_lvl;
    upd_kind_t kind;

    generate
        if (FILTER_IS_MASK) begin : g_mask
            assign allowed = ~filt_vec;
        end else begin : g_enable
            assign allowed = filt_vec;
        end
        if (LOAD_ACTIVE_LOW) begin : g_ld_low
            assign load_lvl = ~hw_load;
        end else begin : g_ld_high
            assign load_lvl = hw_load;
        end
    endgenerate

    always_comb begin
        eff_load = load_lvl | cmd_load;
        eff_clr  = hw_clr | cmd_clr;
        eff_set  = hw_set | cmd_set;
    end

    // Priority selection of the update kind
    always_comb begin
        if (sw_fld_wr)      kind = UPD_SWWR;
        else if (eff_set)   kind = UPD_HSET;
        else if (eff_clr)   kind = UPD_HCLR;
        else if (eff_load)  kind = UPD_HLOAD;
        else                kind = UPD_HOLD;
    end

    // Next-value computation per kind
    always_comb begin
        unique case (kind)
            UPD_SWWR:  fld_d = sw_wdata;
            UPD_HSET:  fld_d = fld_q | allowed;
            UPD_HCLR:  fld_d = fld_q & ~allowed;
            UPD_HLOAD: fld_d = (fld_q & ~allowed) | (hw_value & allowed);
            default:   fld_d = fld_q;
        endcase
    end

endmodule

// File: rtl/hwst_store.sv
module hwst_store #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] fld_d,
    output logic [WIDTH-1:0] fld_q,
    output logic             red_and,
    output logic             red_or,
    output logic             red_xor
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q <= RESET_VAL;
        end else begin
            fld_q <= fld_d;
        end
    end

    always_comb begin
        red_and = &fld_q;
        red_or  = |fld_q;
        red_xor = ^fld_q;
    end

endmodule

// File: rtl/hwst_field.sv
module hwst_field #(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] RESET_VAL       = 8'h11,
    parameter bit               FILTER_IS_MASK  = 1'b0,
    parameter logic [WIDTH-1:0] FILT_RESET      = FILTER_IS_MASK ? '0 : '1,
    parameter bit               LOAD_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       acc_addr,
    input  logic             acc_wr,
    input  logic [WIDTH-1:0] acc_wdata,
    output logic [WIDTH-1:0] acc_rdata,
    input  logic [WIDTH-1:0] hw_value,
    input  logic             hw_load,
    input  logic             hw_clr,
    input  logic             hw_set,
    output logic [WIDTH-1:0] fld_value,
    output logic             red_and,
    output logic             red_or,
    output logic             red_xor
);

    logic [WIDTH-1:0] filt_w;
    logic [WIDTH-1:0] allowed_w;
    logic [WIDTH-1:0] next_w;
    logic             cmd_load_w;
    logic             cmd_clr_w;
    logic             cmd_set_w;
    logic             sw_fld_wr_w;
    logic             eff_load_w;
    logic             eff_clr_w;
    logic             eff_set_w;

    hwst_access #(
        .WIDTH      (WIDTH),
        .FILT_RESET (FILT_RESET)
    ) u_access (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .fld_q     (fld_value),
        .acc_rdata (acc_rdata),
        .filt_vec  (filt_w),
        .cmd_load  (cmd_load_w),
        .cmd_clr   (cmd_clr_w),
        .cmd_set   (cmd_set_w),
        .sw_fld_wr (sw_fld_wr_w)
    );

    hwst_update #(
        .WIDTH           (WIDTH),
        .FILTER_IS_MASK  (FILTER_IS_MASK),
        .LOAD_ACTIVE_LOW (LOAD_ACTIVE_LOW)
    ) u_update (
        .sw_fld_wr (sw_fld_wr_w),
        .sw_wdata  (acc_wdata),
        .fld_q     (fld_value),
        .filt_vec  (filt_w),
        .hw_value  (hw_value),
        .hw_load   (hw_load),
        .hw_clr    (hw_clr),
        .hw_set    (hw_set),
        .cmd_load  (cmd_load_w),
        .cmd_clr   (cmd_clr_w),
        .cmd_set   (cmd_set_w),
        .allowed   (allowed_w),
        .eff_load  (eff_load_w),
        .eff_clr   (eff_clr_w),
        .eff_set   (eff_set_w),
        .fld_d     (next_w)
    );

    hwst_store #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .fld_d   (next_w),
        .fld_q   (fld_value),
        .red_and (red_and),
        .red_or  (red_or),
        .red_xor (red_xor)
    );

endmodule

// File: rtl/hwst_field_chk.sv
module hwst_field_chk #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] fld,
    input logic             r_and,
    input logic             r_or,
    input logic             r_xor,
    input logic [WIDTH-1:0] allowed,
    input logic             sw_wr,
    input logic [WIDTH-1:0] sw_data,
    input logic [WIDTH-1:0] hw_value,
    input logic             e_load,
    input logic             e_clr,
    input logic             e_set
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> fld == RESET_VAL);

    a_r6_sw_wins: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> fld == $past(sw_data));

    a_r5_set_over_clear: assert property (@(posedge clk) disable iff (rst)
        (e_set && !sw_wr) |=> fld == ($past(fld) | $past(allowed)));

    a_r5_clear_over_load: assert property (@(posedge clk) disable iff (rst)
        (e_clr && !e_set && !sw_wr) |=> fld == ($past(fld) & ~$past(allowed)));

    a_r2_load_filtered: assert property (@(posedge clk) disable iff (rst)
        (e_load && !e_clr && !e_set && !sw_wr) |=>
        fld == (($past(fld) & ~$past(allowed)) | ($past(hw_value) & $past(allowed))));

    a_r3_protected_bits: assert property (@(posedge clk) disable iff (rst)
        !sw_wr |=> ((fld ^ $past(fld)) & ~$past(allowed)) == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && !e_load && !e_clr && !e_set) |=> $stable(fld));

    a_r7_and: assert property (@(posedge clk) disable iff (rst)
        r_and == (fld == {WIDTH{1'b1}}));

    a_r7_or: assert property (@(posedge clk) disable iff (rst)
        r_or == (fld != '0));

    a_r7_xor: assert property (@(posedge clk) disable iff (rst)
        r_xor == (($countones(fld) % 2) == 1));

endmodule

bind hwst_field hwst_field_chk #(
    .WIDTH     (WIDTH),
    .RESET_VAL (RESET_VAL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fld      (fld_value),
    .r_and    (red_and),
    .r_or     (red_or),
    .r_xor    (red_xor),
    .allowed  (allowed_w),
    .sw_wr    (sw_fld_wr_w),
    .sw_data  (acc_wdata),
    .hw_value (hw_value),
    .e_load   (eff_load_w),
    .e_clr    (eff_clr_w),
    .e_set    (eff_set_w)
);

// File: tb/hwst_field_tb.sv
module hwst_field_tb;

    typedef struct {
        int         m;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr_s  [2];
    logic       wr_s    [2];
    logic [7:0] wdata_s [2];
    logic [7:0] rdata_s [2];
    logic [7:0] hval_s  [2];
    logic       hld_s   [2];
    logic       hclr_s  [2];
    logic       hset_s  [2];
    logic [7:0] fld_s   [2];
    logic       rand_s  [2];
    logic       ror_s   [2];
    logic       rxor_s  [2];

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    // Enable filter, active-high load
    hwst_field #(.RESET_VAL(8'h11), .FILTER_IS_MASK(1'b0), .LOAD_ACTIVE_LOW(1'b0)) u_dut (
        .clk(clk), .rst(rst), .acc_addr(addr_s[0]), .acc_wr(wr_s[0]),
        .acc_wdata(wdata_s[0]), .acc_rdata(rdata_s[0]), .hw_value(hval_s[0]),
        .hw_load(hld_s[0]), .hw_clr(hclr_s[0]), .hw_set(hset_s[0]),
        .fld_value(fld_s[0]), .red_and(rand_s[0]), .red_or(ror_s[0]), .red_xor(rxor_s[0]));

    // Mask filter, active-low load
    hwst_field #(.RESET_VAL(8'h22), .FILTER_IS_MASK(1'b1), .LOAD_ACTIVE_LOW(1'b1)) u_dut_msk (
        .clk(clk), .rst(rst), .acc_addr(addr_s[1]), .acc_wr(wr_s[1]),
        .acc_wdata(wdata_s[1]), .acc_rdata(rdata_s[1]), .hw_value(hval_s[1]),
        .hw_load(hld_s[1]), .hw_clr(hclr_s[1]), .hw_set(hset_s[1]),
        .fld_value(fld_s[1]), .red_and(rand_s[1]), .red_or(ror_s[1]), .red_xor(rxor_s[1]));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic parity8(input logic [7:0] v);
        logic p = 1'b0;
        for (int i = 0; i < 8; i++) p = p ^ v[i];
        return p;
    endfunction

    // Monitor: compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                chk(it.tag, fld_s[it.m], it.exp);
                chk({it.tag, " R7 and"}, {7'd0, rand_s[it.m]}, {7'd0, it.exp == 8'hFF});
                chk({it.tag, " R7 or"},  {7'd0, ror_s[it.m]},  {7'd0, it.exp != 8'h00});
                chk({it.tag, " R7 xor"}, {7'd0, rxor_s[it.m]}, {7'd0, parity8(it.exp)});
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int m, input logic [7:0] e, input string tag);
        exp_t it;
        it.m = m; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic sw_write(input int m, input logic [1:0] a, input logic [7:0] d);
        addr_s[m] = a; wdata_s[m] = d; wr_s[m] = 1'b1;
        cyc();
        wr_s[m] = 1'b0;
    endtask

    // ld is the logical request; instance 1 has an active-low pin
    task automatic hw_req(input int m, input bit ld, input bit c, input bit s,
                          input logic [7:0] v, input bit with_sw, input logic [7:0] swd,
                          input logic [7:0] e, input string tag);
        hval_s[m] = v;
        hld_s[m]  = (m == 1) ? ~ld : ld;
        hclr_s[m] = c;
        hset_s[m] = s;
        if (with_sw) begin
            addr_s[m] = 2'd0; wdata_s[m] = swd; wr_s[m] = 1'b1;
        end
        cyc();
        wr_s[m]   = 1'b0;
        hld_s[m]  = (m == 1);
        hclr_s[m] = 1'b0;
        hset_s[m] = 1'b0;
        push(m, e, tag);
    endtask

    task automatic read_chk(input int m, input logic [1:0] a, input logic [7:0] e, input string tag);
        addr_s[m] = a;
        @(negedge clk);
        chk(tag, rdata_s[m], e);
        @(posedge clk);
        #1;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            addr_s[m] = 2'd0; wr_s[m] = 1'b0; wdata_s[m] = 8'h00; hval_s[m] = 8'h00;
            hld_s[m] = (m == 1); hclr_s[m] = 1'b0; hset_s[m] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc();

        // R1: reset state
        push(0, 8'h11, "R1 field dut0");
        push(1, 8'h22, "R1 field dut1");
        read_chk(0, 2'd1, 8'hFF, "R1 filter dut0");
        read_chk(1, 2'd1, 8'h00, "R1 filter dut1");
        read_chk(0, 2'd2, 8'h00, "R1 cmd reads zero");

        // R2: enable filter 0xF0
        sw_write(0, 2'd1, 8'hF0);
        hw_req(0, 1, 0, 0, 8'hAB, 0, 8'h00, 8'hA1, "R2 load");
        hw_req(0, 0, 1, 0, 8'h00, 0, 8'h00, 8'h01, "R2 clear");
        hw_req(0, 0, 0, 1, 8'h00, 0, 8'h00, 8'hF1, "R2 set");

        // R3: mask filter 0xF0, active-low load
        sw_write(1, 2'd1, 8'hF0);
        hw_req(1, 1, 0, 0, 8'hAB, 0, 8'h00, 8'h2B, "R3 load");
        hw_req(1, 0, 1, 0, 8'h00, 0, 8'h00, 8'h20, "R3 clear");
        hw_req(1, 0, 0, 1, 8'h00, 0, 8'h00, 8'h2F, "R3 set");

        // R4 / R10: inactive load level leaves the field alone
        hw_req(1, 0, 0, 0, 8'h55, 0, 8'h00, 8'h2F, "R4 dut1 pin high inactive");
        hw_req(0, 0, 0, 0, 8'h55, 0, 8'h00, 8'hF1, "R4 dut0 pin low inactive");
        cyc();
        push(0, 8'hF1, "R10 hold");

        // R6: software write is unfiltered
        sw_write(0, 2'd0, 8'h0F);
        push(0, 8'h0F, "R6 sw write unfiltered");

        // R5: priorities
        hw_req(0, 0, 1, 1, 8'h00, 0, 8'h00, 8'hFF, "R5 set beats clear");
        hw_req(0, 1, 1, 0, 8'h00, 0, 8'h00, 8'h0F, "R5 clear beats load");

        // R6: software beats hardware in the same cycle
        hw_req(0, 0, 0, 1, 8'h00, 1, 8'h3C, 8'h3C, "R6 sw beats set");

        // R7: reductions for several values
        sw_write(0, 2'd0, 8'h00); push(0, 8'h00, "R7 value 00");
        sw_write(0, 2'd0, 8'h03); push(0, 8'h03, "R7 value 03");
        sw_write(0, 2'd0, 8'hFE); push(0, 8'hFE, "R7 value FE");
        sw_write(0, 2'd0, 8'hFF); push(0, 8'hFF, "R7 value FF");

        // R8: command register, filter still 0xF0
        sw_write(0, 2'd2, 8'h02);
        cyc();
        push(0, 8'h0F, "R8 cmd clear");
        read_chk(0, 2'd2, 8'h00, "R8 cmd reads zero");
        hval_s[0] = 8'hA5;
        sw_write(0, 2'd2, 8'h01);
        cyc();
        push(0, 8'hAF, "R8 cmd load");
        sw_write(0, 2'd2, 8'h04);
        cyc();
        push(0, 8'hFF, "R8 cmd set");

        // R9: address 3 has no effect
        sw_write(0, 2'd3, 8'h77);
        push(0, 8'hFF, "R9 write addr3 field unchanged");
        read_chk(0, 2'd1, 8'hF0, "R9 filter unchanged");
        read_chk(0, 2'd3, 8'h00, "R9 addr3 reads zero");
        read_chk(0, 2'd0, 8'hFF, "R9 addr0 reads field");

        cyc();
        cyc();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule